// File: doc/BRIEF.md
# Up/Down/Center-Aligned Timer Counter

This block is the counting core of a general-purpose timer. A CNT_W-bit counter runs up or down against an auto-reload limit in edge-aligned mode. In the three center-aligned modes it sweeps up to the limit and back down to zero. Each wrap or turning point is an overflow or an underflow. Either one produces an update event. An update event can also come from a software strobe or from an external slave-mode pulse.

An update event does three things:
- It moves the buffered reload value into the active limit.
- It can halt the counter when one-pulse operation is selected.
- It can raise a sticky request flag. A source-select bit filters which kinds of update event are allowed to raise that flag.

Software writes the control word, the reload value, the event strobe and the flag clear through a simple write port.

The block also drives two helper outputs:
- A compare-phase qualifier, which tells compare logic outside this block whether the current counting phase may set compare flags.
- A sampling-clock enable at 1, 1/2 or 1/4 of the timer clock, for filter and dead-time logic.

Top module: `tmr_core`

## Requirements
- R1: Edge-aligned mode (control bits [3:2] = 00) with direction bit [1] = 0 counts up by one per cycle while enabled (bit [0]). When the counter is at or above the active limit, the next cycle wraps it to 0 and signals overflow.
- R2: Edge-aligned mode with direction bit = 1 counts down by one per cycle. When the counter is at 0, the next cycle reloads the active limit and signals underflow.
- R3: Center-aligned modes (bits [3:2] = 01, 10, 11) count 0 up to the limit and then back down to 0. At the top the count turns downward (overflow), and at 0 it turns upward (underflow). Each turn is an update event.
- R4: In center-aligned modes, `dir_o` and `ctrl_o[1]` show the direction the hardware is counting in (1 = down). A written direction bit has no effect in these modes.
- R5: `cmp_phase_o` is 1 in edge mode and in mode 11. In mode 01 it is 1 only while counting down. In mode 10 it is 1 only while counting up.
- R6: A control write that would move the alignment from 00 to a center mode while the enable bit is 1 leaves the alignment at 00. The other fields of that write still apply.
- R7: With preload (bit [6]) = 0, a reload write (select 1) changes `arr_o` on the next cycle. With preload = 1, the write is buffered and reaches `arr_o` only on an update event.
- R8: An event-select write (select 2) with data bit 0 set is a software update. So is a pulse on `slave_upd_i`. Either one reinitialises the counter: to 0 when counting up, or to the buffered limit when counting down. It also transfers the buffered limit into `arr_o`.
- R9: With request-source bit [5] = 0, every update event sets the request flag. With bit [5] = 1, only overflow or underflow sets it.
- R10: The request flag holds until a status write (select 3) with data bit 0 = 0 clears it. `upd_req_o` is the flag ANDed with `upd_ie_i`.
- R11: With one-pulse bit [4] = 1, an update event clears the enable bit and the counter stops at its reinitialised value.
- R12: `samp_en_o` is high on every cycle when control bits [8:7] = 00, on one cycle in 2 when they are 01, and on one cycle in 4 when they are 10. The reserved code 11 behaves like 10.
- R13: After reset the counter is 0, the control word is 0, the request output is 0, and the active limit is all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 control, 1 reload, 2 event, 3 status |
| wr_data_i | input | CNT_W | Write data |
| slave_upd_i | input | 1 | Update pulse from slave-mode logic |
| upd_ie_i | input | 1 | Update interrupt/DMA enable |
| cnt_o | output | CNT_W | Counter value |
| arr_o | output | CNT_W | Active auto-reload limit |
| ctrl_o | output | 9 | Control word readback, with the direction bit showing the live direction |
| dir_o | output | 1 | Current counting direction (1 = down) |
| cmp_phase_o | output | 1 | Compare flags may be set in this phase |
| samp_en_o | output | 1 | Divided sampling-clock enable |
| upd_req_o | output | 1 | Update interrupt/DMA request |

## Verification
The assertions check several properties on every cycle:
- single-step counting in edge mode, and the underflow reload;
- the turn to downward counting at the top in center mode;
- a buffered limit holding still when there is no update event;
- the one-pulse stop;
- the stickiness of the request flag;
- the refusal of an edge-to-center switch while running;
- the spacing of the sampling enable.

Only the bench's scenarios can show the rest:
- full count sequences and the values of the compare qualifier in each mode;
- what the source filter does with software and slave updates;
- where a software update reinitialises the counter;
- the number of sampling pulses for each division code.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int CTRL_W = 9;

    typedef enum logic [1:0] {
        ALN_EDGE     = 2'b00,
        ALN_CTR_DN   = 2'b01,
        ALN_CTR_UP   = 2'b10,
        ALN_CTR_BOTH = 2'b11
    } align_e;

    localparam logic [1:0] SEL_CTRL   = 2'd0;
    localparam logic [1:0] SEL_RELOAD = 2'd1;
    localparam logic [1:0] SEL_EVENT  = 2'd2;
    localparam logic [1:0] SEL_STATUS = 2'd3;

    // Packed order gives the bit layout: [8:7] ckd .. [0] en
    typedef struct packed {
        logic [1:0] ckd;
        logic       preload;
        logic       reqsrc;
        logic       opm;
        align_e     align;
        logic       dir;
        logic       en;
    } ctrl_t;

endpackage

// File: rtl/tmr_sampdiv.sv
module tmr_sampdiv #(
    parameter int DIV_W = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] ckd_i,
    output logic       samp_en_o
);
    logic [DIV_W-1:0] div_d, div_q;
    logic [DIV_W-1:0] mask;

    always_comb begin
        div_d = div_q + 1'b1;
        case (ckd_i)
            2'b00:   mask = '0;
            2'b01:   mask = DIV_W'(1);
            default: mask = DIV_W'(3);
        endcase
        samp_en_o = ((div_q & mask) == mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    // R12: at divide-by-4 two pulses are never adjacent
    a_r12_div4_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_en_o && ckd_i[1]) |=> (!samp_en_o || !ckd_i[1]));

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int               CNT_W   = 16,
    parameter logic [CNT_W-1:0] ARR_RST = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_sel_i,
    input  logic [CNT_W-1:0] wr_data_i,
    input  logic             slave_upd_i,
    input  logic             ovf_i,
    input  logic             udf_i,
    output ctrl_t            ctrl_o,
    output logic [CNT_W-1:0] arr_act_o,
    output logic [CNT_W-1:0] arr_shd_o,
    output logic             flag_o,
    output logic             reinit_o
);
    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] arr_act;
        logic [CNT_W-1:0] arr_shd;
        logic             flag;
    } regs_t;

    regs_t s_d, s_q;
    ctrl_t wr_ctrl;
    logic  ctrl_wr, arr_wr, stat_wr, ug, uev;

    always_comb begin
        s_d     = s_q;
        ctrl_wr = wr_en_i && (wr_sel_i == SEL_CTRL);
        arr_wr  = wr_en_i && (wr_sel_i == SEL_RELOAD);
        stat_wr = wr_en_i && (wr_sel_i == SEL_STATUS);
        ug      = wr_en_i && (wr_sel_i == SEL_EVENT) && wr_data_i[0];
        uev     = ovf_i || udf_i || ug || slave_upd_i;
        wr_ctrl = ctrl_t'(wr_data_i[CTRL_W-1:0]);

        // control word: refuse edge->center while running; dir is
        // writable only when the resulting mode is edge-aligned
        if (s_q.ctrl.en && (s_q.ctrl.align == ALN_EDGE))
            wr_ctrl.align = ALN_EDGE;
        if (wr_ctrl.align != ALN_EDGE)
            wr_ctrl.dir = s_q.ctrl.dir;
        if (ctrl_wr)
            s_d.ctrl = wr_ctrl;
        else if (uev && s_q.ctrl.opm)
            s_d.ctrl.en = 1'b0;

        // reload limit with optional buffering
        if (uev)
            s_d.arr_act = s_q.arr_shd;
        if (arr_wr) begin
            s_d.arr_shd = wr_data_i;
            if (!s_q.ctrl.preload)
                s_d.arr_act = wr_data_i;
        end

        // sticky request flag, set wins over clear
        if (stat_wr && !wr_data_i[0])
            s_d.flag = 1'b0;
        if (ovf_i || udf_i || (!s_q.ctrl.reqsrc && (ug || slave_upd_i)))
            s_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.ctrl    <= '0;
            s_q.arr_act <= ARR_RST;
            s_q.arr_shd <= ARR_RST;
            s_q.flag    <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ctrl_o    = s_q.ctrl;
    assign arr_act_o = s_q.arr_act;
    assign arr_shd_o = s_q.arr_shd;
    assign flag_o    = s_q.flag;
    assign reinit_o  = ug || slave_upd_i;

    // R7: a buffered limit holds without an update event
    a_r7_buffered_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ctrl.preload && !ovf_i && !udf_i && !reinit_o) |=> $stable(arr_act_o));

    // R11: one-pulse mode stops the counter at an update event
    a_r11_opm_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ctrl.en && s_q.ctrl.opm && (ovf_i || udf_i || reinit_o) && !ctrl_wr)
        |=> !ctrl_o.en);

    // R10: the flag stays set until a clearing status write
    a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !stat_wr) |=> flag_o);

    // R6: a running edge-aligned counter stays edge-aligned
    a_r6_no_switch_running: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ctrl.en && (s_q.ctrl.align == ALN_EDGE)) |=> (ctrl_o.align == ALN_EDGE));

endmodule

// File: rtl/tmr_count.sv
module tmr_count
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  align_e           align_i,
    input  logic             ctrl_dir_i,
    input  logic [CNT_W-1:0] arr_i,
    input  logic [CNT_W-1:0] arr_shd_i,
    input  logic             reinit_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             dir_o,
    output logic             ovf_o,
    output logic             udf_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             dir;
    } cnt_t;

    cnt_t s_d, s_q;
    logic center, down;

    always_comb begin
        s_d    = s_q;
        ovf_o  = 1'b0;
        udf_o  = 1'b0;
        center = (align_i != ALN_EDGE);
        down   = center ? s_q.dir : ctrl_dir_i;

        if (reinit_i) begin
            s_d.cnt = down ? arr_shd_i : '0;
        end else if (en_i) begin
            if (!down) begin
                if (s_q.cnt >= arr_i) begin
                    ovf_o   = 1'b1;
                    s_d.cnt = (center && (arr_i != '0)) ? arr_i - ONE : '0;
                end else begin
                    s_d.cnt = s_q.cnt + ONE;
                end
            end else begin
                if (s_q.cnt == '0) begin
                    udf_o   = 1'b1;
                    s_d.cnt = center ? ((arr_i != '0) ? ONE : '0) : arr_i;
                end else begin
                    s_d.cnt = s_q.cnt - ONE;
                end
            end
        end

        if (!center)   s_d.dir = ctrl_dir_i;
        else if (ovf_o) s_d.dir = 1'b1;
        else if (udf_o) s_d.dir = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt_o = s_q.cnt;
    assign dir_o = s_q.dir;

    // R1: edge up counting advances by one below the limit
    a_r1_up_step: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !reinit_i && (align_i == ALN_EDGE) && !ctrl_dir_i && (cnt_o < arr_i))
        |=> (cnt_o == $past(cnt_o) + ONE));

    // R2: edge down counting reloads the limit from zero
    a_r2_down_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !reinit_i && (align_i == ALN_EDGE) && ctrl_dir_i && (cnt_o == '0))
        |=> (cnt_o == $past(arr_i)));

    // R3: center mode turns downward at the top
    a_r3_turn_down: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !reinit_i && (align_i != ALN_EDGE) && !dir_o && (cnt_o >= arr_i))
        |=> dir_o);

endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int               CNT_W   = 16,
    parameter logic [CNT_W-1:0] ARR_RST = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_sel_i,
    input  logic [CNT_W-1:0] wr_data_i,
    input  logic             slave_upd_i,
    input  logic             upd_ie_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] arr_o,
    output logic [8:0]       ctrl_o,
    output logic             dir_o,
    output logic             cmp_phase_o,
    output logic             samp_en_o,
    output logic             upd_req_o
);
    ctrl_t            ctrl;
    logic [CNT_W-1:0] arr_shd;
    logic             flag, reinit, ovf, udf, hw_dir;
    ctrl_t            view;

    tmr_regs #(.CNT_W(CNT_W), .ARR_RST(ARR_RST)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
        .slave_upd_i(slave_upd_i), .ovf_i(ovf), .udf_i(udf),
        .ctrl_o(ctrl), .arr_act_o(arr_o), .arr_shd_o(arr_shd),
        .flag_o(flag), .reinit_o(reinit)
    );

    tmr_count #(.CNT_W(CNT_W)) count_i (
        .clk(clk), .rst_n(rst_n),
        .en_i(ctrl.en), .align_i(ctrl.align), .ctrl_dir_i(ctrl.dir),
        .arr_i(arr_o), .arr_shd_i(arr_shd), .reinit_i(reinit),
        .cnt_o(cnt_o), .dir_o(hw_dir), .ovf_o(ovf), .udf_o(udf)
    );

    tmr_sampdiv #(.DIV_W(2)) sampdiv_i (
        .clk(clk), .rst_n(rst_n), .ckd_i(ctrl.ckd), .samp_en_o(samp_en_o)
    );

    always_comb begin
        dir_o    = (ctrl.align == ALN_EDGE) ? ctrl.dir : hw_dir;
        view     = ctrl;
        view.dir = dir_o;
        ctrl_o   = view;
        case (ctrl.align)
            ALN_CTR_DN: cmp_phase_o = dir_o;
            ALN_CTR_UP: cmp_phase_o = !dir_o;
            default:    cmp_phase_o = 1'b1;
        endcase
        upd_req_o = flag && upd_ie_i;
    end

    // R13: immediate reset check
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r13_reset_quiet: assert (cnt_o == '0 && !upd_req_o);
        end
    end

endmodule

// File: tb/tmr_core_tb_top.sv
`timescale 1ns/1ps
module tmr_core_tb_top;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_sel = 2'd0;
    logic [W-1:0] wr_data = '0;
    logic         slave = 1'b0;
    logic         ie = 1'b1;
    logic [W-1:0] cnt, arr;
    logic [8:0]   ctrl;
    logic         dir, cmp, samp, req;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    tmr_core #(.CNT_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
        .wr_data_i(wr_data), .slave_upd_i(slave), .upd_ie_i(ie),
        .cnt_o(cnt), .arr_o(arr), .ctrl_o(ctrl), .dir_o(dir),
        .cmp_phase_o(cmp), .samp_en_o(samp), .upd_req_o(req)
    );

    // {we, sel[1:0], data[15:0], exp_cnt[15:0], exp_req}
    localparam logic [35:0] VEC [0:12] = '{
        {1'b1, 2'd1, 16'h0003, 16'd0, 1'b0},  // R7 reload 3, immediate
        {1'b1, 2'd0, 16'h0001, 16'd0, 1'b0},  // enable, edge up
        {1'b0, 2'd0, 16'h0000, 16'd1, 1'b0},  // R1
        {1'b0, 2'd0, 16'h0000, 16'd2, 1'b0},
        {1'b0, 2'd0, 16'h0000, 16'd3, 1'b0},
        {1'b0, 2'd0, 16'h0000, 16'd0, 1'b1},  // R1 wrap, overflow flag
        {1'b1, 2'd3, 16'h0000, 16'd1, 1'b0},  // R10 clear
        {1'b0, 2'd0, 16'h0000, 16'd2, 1'b0},
        {1'b1, 2'd0, 16'h0003, 16'd3, 1'b0},  // switch to down
        {1'b0, 2'd0, 16'h0000, 16'd2, 1'b0},  // R2
        {1'b0, 2'd0, 16'h0000, 16'd1, 1'b0},
        {1'b0, 2'd0, 16'h0000, 16'd0, 1'b0},
        {1'b0, 2'd0, 16'h0000, 16'd3, 1'b1}   // R2 underflow reload
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic we, input logic [1:0] sel,
                        input logic [W-1:0] data, input logic slv);
        @(negedge clk);
        wr_en = we; wr_sel = sel; wr_data = data; slave = slv;
        @(posedge clk);
        #1;
        wr_en = 1'b0; slave = 1'b0;
    endtask

    task automatic idle();
        step(1'b0, 2'd0, '0, 1'b0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; slave = 1'b0; ie = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic count_samp(input int exp, input string tag);
        int n = 0;
        for (int i = 0; i < 8; i++) begin
            idle();
            if (samp) n++;
        end
        chk(tag, n, exp);
    endtask

    initial begin
        do_reset();
        #1;
        // R13 reset state
        chk("R13 cnt", cnt, 0);
        chk("R13 req", req, 0);
        chk("R13 ctrl", ctrl, 0);
        chk("R13 arr", arr, 16'hFFFF);

        // vector table: edge up then edge down
        for (int v = 0; v < 13; v++) begin
            step(VEC[v][35], VEC[v][34:33], VEC[v][32:17], 1'b0);
            chk($sformatf("R1/R2 vec%0d cnt", v), cnt, VEC[v][16:1]);
            chk($sformatf("R10 vec%0d req", v), req, VEC[v][0]);
        end

        // R7 buffered reload, R8 software update
        do_reset();
        step(1'b1, 2'd0, 16'h0040, 1'b0);
        step(1'b1, 2'd1, 16'd5, 1'b0);
        chk("R7 buffered write held", arr, 16'hFFFF);
        step(1'b1, 2'd2, 16'h0001, 1'b0);
        chk("R8 transfer on update", arr, 5);
        chk("R8 reinit up", cnt, 0);
        chk("R9 sw update sets flag", req, 1);

        // R9 source filter, R10 gating
        step(1'b1, 2'd3, 16'h0000, 1'b0);
        chk("R10 cleared", req, 0);
        step(1'b1, 2'd0, 16'h0060, 1'b0);
        step(1'b1, 2'd2, 16'h0001, 1'b0);
        chk("R9 sw update filtered", req, 0);
        step(1'b0, 2'd0, '0, 1'b1);
        chk("R9 slave update filtered", req, 0);
        step(1'b1, 2'd0, 16'h0040, 1'b0);
        step(1'b0, 2'd0, '0, 1'b1);
        chk("R9 slave update sets flag", req, 1);
        ie = 1'b0; #1;
        chk("R10 enable gates request", req, 0);
        ie = 1'b1; #1;
        chk("R10 flag still held", req, 1);

        // R8 reinit when counting down
        do_reset();
        step(1'b1, 2'd0, 16'h0002, 1'b0);
        step(1'b1, 2'd1, 16'd7, 1'b0);
        step(1'b1, 2'd2, 16'h0001, 1'b0);
        chk("R8 reinit down", cnt, 7);

        // R3 center mode 11, R4, R5
        do_reset();
        step(1'b1, 2'd1, 16'd2, 1'b0);
        step(1'b1, 2'd0, 16'h000D, 1'b0);
        chk("R3 start", cnt, 0);
        idle(); chk("R3 c1", cnt, 1);
        idle(); chk("R3 c2", cnt, 2); chk("R4 dir up", dir, 0);
        idle(); chk("R3 turn", cnt, 1); chk("R4 dir down", dir, 1);
        chk("R3 top update flag", req, 1); chk("R5 mode11 cmp", cmp, 1);
        idle(); chk("R3 bottom", cnt, 0);
        idle(); chk("R3 rise", cnt, 1); chk("R4 dir up again", dir, 0);
        step(1'b1, 2'd0, 16'h000F, 1'b0);
        chk("R4 dir write ignored", dir, 0);
        chk("R4 ctrl dir view", ctrl[1], 0);
        chk("R3 keeps counting", cnt, 2);

        // R5 modes 01 and 10
        do_reset();
        step(1'b1, 2'd1, 16'd2, 1'b0);
        step(1'b1, 2'd0, 16'h0005, 1'b0);
        chk("R5 mode01 up", cmp, 0);
        idle(); idle(); idle();
        chk("R5 mode01 down dir", dir, 1);
        chk("R5 mode01 down", cmp, 1);
        step(1'b1, 2'd0, 16'h0009, 1'b0);
        chk("R5 mode10 down", cmp, 0);

        // R6 refused switch while running
        do_reset();
        step(1'b1, 2'd0, 16'h0001, 1'b0);
        step(1'b1, 2'd0, 16'h000D, 1'b0);
        chk("R6 align held", ctrl[3:2], 0);
        chk("R6 enable applied", ctrl[0], 1);
        step(1'b1, 2'd0, 16'h0000, 1'b0);
        step(1'b1, 2'd0, 16'h000C, 1'b0);
        chk("R6 switch when stopped", ctrl, 9'h00C);

        // R11 one-pulse
        do_reset();
        step(1'b1, 2'd1, 16'd2, 1'b0);
        step(1'b1, 2'd0, 16'h0011, 1'b0);
        idle(); idle(); idle();
        chk("R11 wrapped", cnt, 0);
        chk("R11 enable cleared", ctrl[0], 0);
        idle();
        chk("R11 stopped", cnt, 0);

        // R12 sampling enable
        do_reset();
        count_samp(8, "R12 div1");
        step(1'b1, 2'd0, 16'h0080, 1'b0);
        count_samp(4, "R12 div2");
        step(1'b1, 2'd0, 16'h0100, 1'b0);
        count_samp(2, "R12 div4");
        step(1'b1, 2'd0, 16'h0180, 1'b0);
        count_samp(2, "R12 reserved as div4");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule